// File: doc/BRIEF.md
# Fetch Thread Selector

This block decides, every cycle, which hardware thread a multithreaded instruction fetch stage works on. Each thread reports a 3-bit fetch-status code. Only a few of those codes mean that the thread can take a fetch slot, so eligibility is decoded from the status and is not a plain request bit. The selection is combinational and appears on `grant_valid` and `grant_tid` in the same cycle as the inputs.

Two policies are supported. In the static policy the fetch stage always serves thread 0. In the rotating policy the block keeps an ordered list of all thread IDs and scans it from the head. The first eligible thread wins. When the fetch stage consumes that grant by raising `fetch_accept`, the winner is taken out of its place and appended at the tail, and the other threads keep their relative order. When only one thread is configured, the policy input is ignored. The block then serves the lowest thread marked active, if that thread's status is eligible.

Top module: `fts_thread_select`

## Requirements
- R1: Status codes are 0 running, 1 idle, 2 squashing, 3 blocked, 4 miss pending, 5 miss returned, 6 quiesce, 7 trap. Only codes 0, 1 and 5 make a thread eligible.
- R2: In rotating mode with more than one configured thread, the grant goes to the eligible thread that stands closest to the head of the order list. Only threads with ID below the configured count are considered.
- R3: In rotating mode, a valid grant together with `fetch_accept` moves the granted ID to the tail of the list at the next clock edge. All other IDs keep their relative order.
- R4: Without `fetch_accept` the order list keeps its value, so the same inputs keep producing the same grant.
- R5: With more than one configured thread and `policy_rr`=0, `grant_valid` is 1 and `grant_tid` is 0 whatever the statuses. The order list is not changed, even when `fetch_accept` is high.
- R6: With one configured thread, the candidate is the lowest set bit of `active_mask`. It is granted only if its status is eligible, otherwise no thread is granted. The order list is not changed.
- R7: When no thread can be granted, `grant_valid` is 0 and `fetch_accept` leaves the order list unchanged.
- R8: After reset the order list is 0, 1, 2, 3 from head to tail.
- R9: `cfg_threads` values 0 and 1 both mean one thread. Values above the thread maximum (4) mean the maximum.
- R10: The grant outputs depend combinationally on the present inputs and on the registered list, with no cycle of latency. When `grant_valid` is 0, `grant_tid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_status | input | 12 | Per-thread status codes; thread t at bits [3t+2:3t] |
| active_mask | input | 4 | Active-thread mask, bit t for thread t |
| policy_rr | input | 1 | 1 selects rotating policy, 0 static thread 0 |
| cfg_threads | input | 3 | Configured number of threads |
| fetch_accept | input | 1 | Fetch stage consumes the current grant |
| grant_valid | output | 1 | A thread is granted this cycle |
| grant_tid | output | 2 | Granted thread ID |

## Verification
Every one of the eight status codes is placed on a lone candidate thread, which separates the eligible codes from the ineligible ones. With all threads eligible and accepts held high, the grants must walk 0, 1, 2, 3 in turn. Scattered eligibility and skipped threads then show that list rotation differs from a rotating pointer, because a skipped thread keeps its place near the head. All sixteen active masks are swept in single-thread configuration, and the static policy is run with accepts held high, to show that neither path disturbs the stored order. A long pseudo-random mix of counts, policies, masks and accepts is then compared against an arithmetic model of the list.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_SQUASH    = 3'd2,
    ST_BLOCK     = 3'd3,
    ST_MISS_WAIT = 3'd4,
    ST_MISS_DONE = 3'd5,
    ST_QUIESCE   = 3'd6,
    ST_TRAP      = 3'd7
  } fetch_stat_e;

  function automatic logic stat_can_fetch(input logic [STAT_W-1:0] code);
    logic ok;
    case (fetch_stat_e'(code))
      ST_RUN, ST_IDLE, ST_MISS_DONE: ok = 1'b1;
      default:                       ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/fts_elig_vec.sv
module fts_elig_vec
  import fts_pkg::*;
#(
  parameter int N_THR = 4,
  parameter int CNT_W = 3
) (
  input  logic [N_THR*STAT_W-1:0] thr_status,
  input  logic [CNT_W-1:0]        cnt_eff,
  output logic [N_THR-1:0]        stat_ok,
  output logic [N_THR-1:0]        rr_ok
);

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    always_comb begin
      stat_ok[t] = stat_can_fetch(thr_status[t*STAT_W +: STAT_W]);
      rr_ok[t]   = stat_ok[t] && (CNT_W'(t) < cnt_eff);
    end
  end

endmodule

// File: rtl/fts_rr_pick.sv
module fts_rr_pick #(
  parameter int N_THR = 4,
  parameter int TID_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_THR*TID_W-1:0] order_flat,
  input  logic [N_THR-1:0]       rr_ok,
  output logic                   hit,
  output logic [TID_W-1:0]       hit_tid,
  output logic [TID_W-1:0]       hit_pos
);

  logic [N_THR-1:0] slot_ok;

  for (genvar p = 0; p < N_THR; p++) begin : g_slot
    always_comb slot_ok[p] = rr_ok[order_flat[p*TID_W +: TID_W]];
  end

  always_comb begin
    hit     = 1'b0;
    hit_tid = '0;
    hit_pos = '0;
    for (int p = N_THR - 1; p >= 0; p--) begin
      if (slot_ok[p]) begin
        hit     = 1'b1;
        hit_tid = order_flat[p*TID_W +: TID_W];
        hit_pos = TID_W'(p);
      end
    end
  end

  // R2: a hit always names a thread that the eligibility logic marked
  p_hit_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> rr_ok[hit_tid]);

  // R7: no hit exactly when no candidate thread is eligible
  p_nohit_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rr_ok == '0));

endmodule

// File: rtl/fts_prio_order.sv
module fts_prio_order #(
  parameter int N_THR = 4,
  parameter int TID_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_en,
  input  logic [TID_W-1:0]       upd_pos,
  output logic [N_THR*TID_W-1:0] order_flat
);

  logic [TID_W-1:0] order_q [N_THR];
  logic [TID_W-1:0] order_d [N_THR];
  logic [TID_W-1:0] moved_id;

  always_comb moved_id = order_q[upd_pos];

  always_comb begin
    for (int p = 0; p < N_THR; p++) begin
      order_d[p] = order_q[p];
      if (upd_en) begin
        if (p == N_THR - 1)
          order_d[p] = moved_id;
        else if (TID_W'(p) >= upd_pos)
          order_d[p] = order_q[p+1];
      end
    end
  end

  for (genvar p = 0; p < N_THR; p++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        order_q[p] <= TID_W'(p);
      else if (upd_en)
        order_q[p] <= order_d[p];
    end
    always_comb order_flat[p*TID_W +: TID_W] = order_q[p];
  end

  logic [N_THR-1:0] present;
  always_comb begin
    present = '0;
    for (int p = 0; p < N_THR; p++) present[order_q[p]] = 1'b1;
  end

  // R3: the list always stays a permutation of all thread IDs
  p_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == N_THR);

  // R3: the consumed ID lands at the tail one edge later
  p_tail_is_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> order_q[N_THR-1] == $past(moved_id));

  // R3: entries ahead of the moved one keep their place
  p_head_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_pos != '0) |=> order_q[0] == $past(order_q[0]));

  // R4: no update, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(order_flat));

endmodule

// File: rtl/fts_thread_select.sv
module fts_thread_select
  import fts_pkg::*;
#(
  parameter int N_THR = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_THR*3-1:0]      thr_status,
  input  logic [N_THR-1:0]        active_mask,
  input  logic                    policy_rr,
  input  logic [2:0]              cfg_threads,
  input  logic                    fetch_accept,
  output logic                    grant_valid,
  output logic [$clog2(N_THR)-1:0] grant_tid
);

  localparam int TID_W = $clog2(N_THR);
  localparam int CNT_W = 3;

  logic [CNT_W-1:0]       cnt_eff;
  logic                   multi;
  logic [N_THR-1:0]       stat_ok;
  logic [N_THR-1:0]       rr_ok;
  logic [N_THR*TID_W-1:0] order_flat;
  logic                   rr_hit;
  logic [TID_W-1:0]       rr_tid;
  logic [TID_W-1:0]       rr_pos;
  logic                   any_act;
  logic [TID_W-1:0]       first_act;
  logic                   upd_en;

  // R9: clamp the configured count
  always_comb begin
    if (cfg_threads == '0)
      cnt_eff = CNT_W'(1);
    else if (cfg_threads > CNT_W'(N_THR))
      cnt_eff = CNT_W'(N_THR);
    else
      cnt_eff = cfg_threads;
    multi = (cnt_eff > CNT_W'(1));
  end

  fts_elig_vec #(.N_THR(N_THR), .CNT_W(CNT_W)) u_elig (
    .thr_status (thr_status),
    .cnt_eff    (cnt_eff),
    .stat_ok    (stat_ok),
    .rr_ok      (rr_ok)
  );

  fts_prio_order #(.N_THR(N_THR), .TID_W(TID_W)) u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .upd_pos    (rr_pos),
    .order_flat (order_flat)
  );

  fts_rr_pick #(.N_THR(N_THR), .TID_W(TID_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .order_flat (order_flat),
    .rr_ok      (rr_ok),
    .hit        (rr_hit),
    .hit_tid    (rr_tid),
    .hit_pos    (rr_pos)
  );

  always_comb begin
    any_act   = 1'b0;
    first_act = '0;
    for (int t = N_THR - 1; t >= 0; t--) begin
      if (active_mask[t]) begin
        any_act   = 1'b1;
        first_act = TID_W'(t);
      end
    end
  end

  always_comb begin
    grant_valid = 1'b0;
    grant_tid   = '0;
    if (!multi) begin
      if (any_act && stat_ok[first_act]) begin
        grant_valid = 1'b1;
        grant_tid   = first_act;
      end
    end else if (!policy_rr) begin
      grant_valid = 1'b1;
    end else if (rr_hit) begin
      grant_valid = 1'b1;
      grant_tid   = rr_tid;
    end
  end

  always_comb upd_en = fetch_accept && policy_rr && multi && rr_hit;

  // R5: static policy always serves thread 0
  p_static_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && !policy_rr) |-> (grant_valid && grant_tid == '0));

  // R6: single-thread grant is the lowest active thread
  p_single_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi && grant_valid) |-> (active_mask[grant_tid] &&
      ((active_mask & ((N_THR'(1) << grant_tid) - N_THR'(1))) == '0)));

  // R10: an idle grant carries thread 0
  p_idle_tid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant_tid == '0);

  // R1: a granted thread never holds a non-fetching status in single mode
  p_single_stat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi && grant_valid) |-> stat_can_fetch(thr_status[grant_tid*3 +: 3]));

endmodule

// File: tb/fts_thread_select_tb_top.sv
module fts_thread_select_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] thr_status;
  logic [3:0]  active_mask;
  logic        policy_rr;
  logic [2:0]  cfg_threads;
  logic        fetch_accept;
  logic        grant_valid;
  logic [1:0]  grant_tid;

  int n_checks = 0;
  int n_errors = 0;
  int q [4];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  fts_thread_select dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_status   (thr_status),
    .active_mask  (active_mask),
    .policy_rr    (policy_rr),
    .cfg_threads  (cfg_threads),
    .fetch_accept (fetch_accept),
    .grant_valid  (grant_valid),
    .grant_tid    (grant_tid)
  );

  function automatic logic ok_code(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd5);
  endfunction

  task automatic chk(input logic cond, input string tag, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [11:0] st, input logic [3:0] msk, input logic [2:0] cnt,
                     input logic pol, input logic acc, input string tag);
    int ce;
    int first;
    int pos;
    int et;
    int tmp;
    logic ev;
    @(negedge clk);
    thr_status = st; active_mask = msk; cfg_threads = cnt;
    policy_rr = pol; fetch_accept = acc;
    #1;
    ce = (cnt == 0) ? 1 : ((cnt > 4) ? 4 : int'(cnt));
    ev = 1'b0; et = 0; pos = -1;
    if (ce == 1) begin
      first = -1;
      for (int i = 0; i < 4; i++) if (msk[i] && first < 0) first = i;
      if (first >= 0 && ok_code(st[first*3 +: 3])) begin ev = 1'b1; et = first; end
    end else if (!pol) begin
      ev = 1'b1; et = 0;
    end else begin
      for (int p = 0; p < 4; p++)
        if (!ev && q[p] < ce && ok_code(st[q[p]*3 +: 3])) begin ev = 1'b1; et = q[p]; pos = p; end
    end
    chk(grant_valid == ev, {tag, " valid"}, int'(grant_valid), int'(ev));
    chk(int'(grant_tid) == et, {tag, " tid"}, int'(grant_tid), et);
    @(posedge clk);
    if (acc && pol && ce > 1 && ev) begin
      tmp = q[pos];
      for (int p = pos; p < 3; p++) q[p] = q[p+1];
      q[3] = tmp;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    thr_status = '0; active_mask = 4'hF; policy_rr = 1'b1;
    cfg_threads = 3'd4; fetch_accept = 1'b0;
    for (int i = 0; i < 4; i++) q[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8 reset order: all eligible, head is thread 0; R4 held without accept
    cyc(12'h000, 4'hF, 3'd4, 1'b1, 1'b0, "R8 reset head");
    cyc(12'h000, 4'hF, 3'd4, 1'b1, 1'b0, "R4 hold");
    // R3 rotation through all threads
    for (int k = 0; k < 8; k++) cyc(12'h000, 4'hF, 3'd4, 1'b1, 1'b1, "R3 rotate");
    // R1 each code on thread 2, others blocked (code 3)
    for (int c = 0; c < 8; c++) begin
      logic [11:0] s;
      s = 12'b011_011_011_011;
      s[8:6] = 3'(c);
      cyc(s, 4'hF, 3'd4, 1'b1, 1'b1, "R1 code rr");
      cyc({9'b0, 3'(c)}, 4'h1, 3'd1, 1'b1, 1'b0, "R1 code single");
    end
    // R2 skip pattern: only threads 1,3 eligible
    for (int k = 0; k < 6; k++) cyc(12'b001_011_101_011, 4'hF, 3'd4, 1'b1, 1'b1, "R2 skip");
    // R7 nothing eligible, accept high; then reveal list
    for (int k = 0; k < 3; k++) cyc(12'b111_110_100_010, 4'hF, 3'd4, 1'b1, 1'b1, "R7 none");
    cyc(12'h000, 4'hF, 3'd4, 1'b1, 1'b0, "R7 list kept");
    // R5 static policy, accept high, mixed statuses
    for (int c = 2; c < 8; c++) cyc(12'b011_100_110_111, 4'h0, 3'(c), 1'b0, 1'b1, "R5 static");
    cyc(12'h000, 4'hF, 3'd4, 1'b1, 1'b0, "R5 list kept");
    // R6 all masks, single thread, R9 counts 0 and 1
    for (int m = 0; m < 16; m++) begin
      cyc(12'b000_011_001_111, 4'(m), 3'd1, 1'b1, 1'b1, "R6 mask");
      cyc(12'b101_110_000_010, 4'(m), 3'd0, 1'b0, 1'b1, "R9 zero count");
    end
    cyc(12'h000, 4'hF, 3'd4, 1'b1, 1'b0, "R6 list kept");
    // R9 count clamp and count limit of rr scan
    for (int k = 0; k < 6; k++) cyc(12'h000, 4'hF, 3'd7, 1'b1, 1'b1, "R9 clamp");
    for (int k = 0; k < 6; k++) cyc(12'h000, 4'hF, 3'd2, 1'b1, 1'b1, "R2 count two");
    // R10 pseudo-random mix
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[11:0] & {6'h3F, lfsr[15:10]}, lfsr[15:12], lfsr[2:0] ^ lfsr[9:7],
          lfsr[5] | lfsr[14], lfsr[3], "R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule